// File: doc/BRIEF.md
# Rendezvous Word Synchronization Controller

This block holds a small array of 64-bit words and pairs a producer thread with a consumer thread on any one of those words. Each word carries a claim flag. When that flag is set, the word no longer holds data. It holds the thread number of the side that is waiting. The side that reaches a word first claims it and is told at once that it is suspended. When the partner side arrives, the value moves across, the waiting thread gets a wake event, and the claim is dropped.

A producer that arrives first has nowhere to put its value while the word holds its own thread number. The value is therefore parked in a per-word holding register. It is copied into the word when the consumer completes the pairing. A consumer that arrives first leaves the word claimed. The later producer writes its value straight into the word, and the woken consumer can then fetch it with a plain load. Plain loads and stores share the array, and they are refused while a word is claimed.

A double-buffered stream uses two flag words. The two sides alternate between them, so one buffer fills while the other drains.

Only one request is served in each cycle. The producer port has the highest priority, then the consumer port, then the plain port. A request that loses is answered busy and must be repeated.

Top module: `rndzv_sync`

## Requirements
- R1: After reset no word is claimed, every word reads as zero through the plain port, and `wake_valid` is low.
- R2: A producer request on an unclaimed word raises `prod_suspend` in the same cycle. The word is then claimed by that producer, and the request's data is held aside.
- R3: A consumer request on a word claimed by a producer raises `cons_done` in the same cycle, with `cons_rdata` equal to the held data. From the next cycle the word is unclaimed and contains that data.
- R4: A consumer request on an unclaimed word raises `cons_suspend` in the same cycle, and the word becomes claimed by that consumer.
- R5: A producer request on a word claimed by a consumer raises `prod_done` in the same cycle. From the next cycle the word is unclaimed and holds the producer's data.
- R6: A second arrival of the same kind on a claimed word (producer on a producer claim, or consumer on a consumer claim) is answered busy and changes nothing.
- R7: A plain read of a claimed word returns `mem_busy` high and `mem_rdata` zero. A plain write to a claimed word returns busy and is discarded.
- R8: On an unclaimed word a plain read returns the stored value in the same cycle, and a plain write is visible from the next cycle.
- R9: When requests arrive together, the producer port is served first, then the consumer port, then the plain port. A request that is not served gets its busy output and has no effect.
- R10: `wake_valid` is high for exactly the one cycle after each `prod_done` or `cons_done`. `wake_tid` then carries the thread number of the sleeper that recorded the claim. In all other cycles `wake_valid` is low.
- R11: `cons_rdata` is zero in any cycle without `cons_done`. The suspend, done and busy outputs of a port are mutually exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_req | input | 1 | Producer rendezvous store request |
| prod_addr | input | ADDR_W | Word address of producer request |
| prod_tid | input | TID_W | Producer thread number |
| prod_data | input | DATA_W | Value the producer hands over |
| prod_suspend | output | 1 | Producer arrived first and sleeps |
| prod_done | output | 1 | Producer completed a pairing |
| prod_busy | output | 1 | Producer request refused, retry |
| cons_req | input | 1 | Consumer rendezvous load request |
| cons_addr | input | ADDR_W | Word address of consumer request |
| cons_tid | input | TID_W | Consumer thread number |
| cons_suspend | output | 1 | Consumer arrived first and sleeps |
| cons_done | output | 1 | Consumer completed a pairing |
| cons_busy | output | 1 | Consumer request refused, retry |
| cons_rdata | output | DATA_W | Value handed to the consumer |
| mem_req | input | 1 | Plain load/store request |
| mem_we | input | 1 | 1 = store, 0 = load |
| mem_addr | input | ADDR_W | Plain access word address |
| mem_wdata | input | DATA_W | Plain store data |
| mem_rdata | output | DATA_W | Plain load data (zero when busy) |
| mem_busy | output | 1 | Plain access refused |
| wake_valid | output | 1 | One-cycle wake event |
| wake_tid | output | TID_W | Thread number to wake |

## Verification
The hardest situation to reach from the ports is a completion whose wake number must come out of the claimed word itself, especially while another port is fighting for the same cycle. A completion needs a matching claim set up earlier by the opposite side. The bench builds such claims with directed producer-first, consumer-first and same-cycle collision sequences. It then runs a long random phase confined to four addresses, so claims, repeats and completions keep landing on the same words. A behavioural model follows every cycle and predicts each response and each wake.

// File: rtl/rndzv_sync.sv
module rndzv_sync #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int TID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prod_req,
  input  logic [ADDR_W-1:0] prod_addr,
  input  logic [TID_W-1:0]  prod_tid,
  input  logic [DATA_W-1:0] prod_data,
  output logic              prod_suspend,
  output logic              prod_done,
  output logic              prod_busy,
  input  logic              cons_req,
  input  logic [ADDR_W-1:0] cons_addr,
  input  logic [TID_W-1:0]  cons_tid,
  output logic              cons_suspend,
  output logic              cons_done,
  output logic              cons_busy,
  output logic [DATA_W-1:0] cons_rdata,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_busy,
  output logic              wake_valid,
  output logic [TID_W-1:0]  wake_tid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = DATA_W - TID_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DATA_W-1:0] park_q [DEPTH];
  logic [DEPTH-1:0]  own_q;
  logic [DEPTH-1:0]  by_prod_q;

  logic p_own, p_byp, c_own, c_byp, m_own, c_go, m_go;

  assign p_own = own_q[prod_addr];
  assign p_byp = by_prod_q[prod_addr];
  assign c_own = own_q[cons_addr];
  assign c_byp = by_prod_q[cons_addr];
  assign m_own = own_q[mem_addr];

  assign c_go = cons_req & ~prod_req;
  assign m_go = mem_req & ~prod_req & ~cons_req;

  assign prod_suspend = prod_req & ~p_own;
  assign prod_done    = prod_req & p_own & ~p_byp;
  assign prod_busy    = prod_req & p_own & p_byp;

  assign cons_suspend = c_go & ~c_own;
  assign cons_done    = c_go & c_own & c_byp;
  assign cons_busy    = cons_req & (prod_req | (c_own & ~c_byp));
  assign cons_rdata   = cons_done ? park_q[cons_addr] : '0;

  assign mem_busy  = mem_req & ~(m_go & ~m_own);
  assign mem_rdata = (m_go & ~m_own & ~mem_we) ? word_q[mem_addr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q      <= '0;
      by_prod_q  <= '0;
      wake_valid <= 1'b0;
      wake_tid   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        word_q[i] <= '0;
        park_q[i] <= '0;
      end
    end else begin
      wake_valid <= prod_done | cons_done;
      if (prod_done)
        wake_tid <= word_q[prod_addr][TID_W-1:0];
      else if (cons_done)
        wake_tid <= word_q[cons_addr][TID_W-1:0];

      if (prod_suspend) begin
        own_q[prod_addr]     <= 1'b1;
        by_prod_q[prod_addr] <= 1'b1;
        word_q[prod_addr]    <= {{PAD_W{1'b0}}, prod_tid};
        park_q[prod_addr]    <= prod_data;
      end else if (prod_done) begin
        own_q[prod_addr]  <= 1'b0;
        word_q[prod_addr] <= prod_data;
      end else if (cons_suspend) begin
        own_q[cons_addr]     <= 1'b1;
        by_prod_q[cons_addr] <= 1'b0;
        word_q[cons_addr]    <= {{PAD_W{1'b0}}, cons_tid};
      end else if (cons_done) begin
        own_q[cons_addr]  <= 1'b0;
        word_q[cons_addr] <= park_q[cons_addr];
      end else if (m_go & mem_we & ~m_own) begin
        word_q[mem_addr] <= mem_wdata;
      end
    end
  end
endmodule

// File: rtl/rndzv_sync_chk.sv
module rndzv_sync_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prod_req,
  input logic              cons_req,
  input logic              prod_suspend,
  input logic              prod_done,
  input logic              prod_busy,
  input logic              cons_suspend,
  input logic              cons_done,
  input logic              cons_busy,
  input logic [DATA_W-1:0] cons_rdata,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_busy,
  input logic              wake_valid
);
  a_r10_wake_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_done | cons_done) |=> wake_valid);
  a_r10_no_stray_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !(prod_done | cons_done) |=> !wake_valid);
  a_r11_prod_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prod_suspend, prod_done, prod_busy}));
  a_r11_cons_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cons_suspend, cons_done, cons_busy}));
  a_r11_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_done |-> cons_rdata == '0);
  a_r9_consumer_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_req & cons_req) |-> cons_busy);
  a_r9_one_served: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({prod_suspend, prod_done, cons_suspend, cons_done}) <= 1);
  a_r7_busy_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> mem_rdata == '0);
endmodule

bind rndzv_sync rndzv_sync_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .cons_req(cons_req),
  .prod_suspend(prod_suspend), .prod_done(prod_done), .prod_busy(prod_busy),
  .cons_suspend(cons_suspend), .cons_done(cons_done), .cons_busy(cons_busy),
  .cons_rdata(cons_rdata), .mem_rdata(mem_rdata), .mem_busy(mem_busy),
  .wake_valid(wake_valid)
);

// File: tb/rndzv_sync_bench.sv
`timescale 1ns/1ps
module rndzv_sync_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prod_req = 0, cons_req = 0, mem_req = 0, mem_we = 0;
  logic [3:0] prod_addr = 0, cons_addr = 0, mem_addr = 0;
  logic [7:0] prod_tid = 0, cons_tid = 0;
  logic [63:0] prod_data = 0, mem_wdata = 0;
  logic prod_suspend, prod_done, prod_busy, cons_suspend, cons_done, cons_busy;
  logic mem_busy, wake_valid;
  logic [63:0] cons_rdata, mem_rdata;
  logic [7:0] wake_tid;

  always #10 clk = ~clk;

  rndzv_sync u_rndzv_sync (
    .clk(clk), .rst_n(rst_n),
    .prod_req(prod_req), .prod_addr(prod_addr), .prod_tid(prod_tid), .prod_data(prod_data),
    .prod_suspend(prod_suspend), .prod_done(prod_done), .prod_busy(prod_busy),
    .cons_req(cons_req), .cons_addr(cons_addr), .cons_tid(cons_tid),
    .cons_suspend(cons_suspend), .cons_done(cons_done), .cons_busy(cons_busy),
    .cons_rdata(cons_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_busy(mem_busy),
    .wake_valid(wake_valid), .wake_tid(wake_tid)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  bit          m_own   [16];
  bit          m_kprod [16];
  logic [63:0] m_val   [16];
  logic [63:0] m_side  [16];
  logic [7:0]  m_tid   [16];
  bit          ew_v = 0;
  logic [7:0]  ew_t = 0;

  task automatic chk(input string name, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", name, got, exp);
    end
  endtask

  task automatic step(input bit pr, input logic [3:0] pa, input logic [7:0] pt, input logic [63:0] pd,
                      input bit cr, input logic [3:0] ca, input logic [7:0] ct,
                      input bit mr, input bit mw, input logic [3:0] ma, input logic [63:0] md);
    bit e_ps = 0, e_pb = 0, e_pd = 0, e_cs = 0, e_cb = 0, e_cd = 0, e_mb = 0, nv = 0;
    logic [63:0] e_crd = 0, e_mrd = 0;
    logic [7:0] nt = 0;
    prod_req = pr; prod_addr = pa; prod_tid = pt; prod_data = pd;
    cons_req = cr; cons_addr = ca; cons_tid = ct;
    mem_req = mr; mem_we = mw; mem_addr = ma; mem_wdata = md;
    #1;
    chk("R10 wake_valid", {63'd0, wake_valid}, {63'd0, ew_v});
    if (ew_v) chk("R10 wake_tid", {56'd0, wake_tid}, {56'd0, ew_t});
    if (pr) begin
      if (!m_own[pa]) e_ps = 1;
      else if (m_kprod[pa]) e_pb = 1;
      else begin e_pd = 1; nv = 1; nt = m_tid[pa]; end
    end
    if (cr) begin
      if (pr) e_cb = 1;
      else if (!m_own[ca]) e_cs = 1;
      else if (!m_kprod[ca]) e_cb = 1;
      else begin e_cd = 1; e_crd = m_side[ca]; nv = 1; nt = m_tid[ca]; end
    end
    if (mr) begin
      if (pr || cr || m_own[ma]) e_mb = 1;
      else if (!mw) e_mrd = m_val[ma];
    end
    chk("R2 prod_suspend", {63'd0, prod_suspend}, {63'd0, e_ps});
    chk("R5 prod_done",    {63'd0, prod_done},    {63'd0, e_pd});
    chk("R6 prod_busy",    {63'd0, prod_busy},    {63'd0, e_pb});
    chk("R4 cons_suspend", {63'd0, cons_suspend}, {63'd0, e_cs});
    chk("R3 cons_done",    {63'd0, cons_done},    {63'd0, e_cd});
    chk("R9 cons_busy",    {63'd0, cons_busy},    {63'd0, e_cb});
    chk("R3 cons_rdata",   cons_rdata, e_crd);
    chk("R7 mem_busy",     {63'd0, mem_busy},     {63'd0, e_mb});
    chk("R8 mem_rdata",    mem_rdata, e_mrd);
    @(posedge clk); #1;
    if (e_ps) begin m_own[pa] = 1; m_kprod[pa] = 1; m_tid[pa] = pt; m_side[pa] = pd; end
    if (e_pd) begin m_own[pa] = 0; m_val[pa] = pd; end
    if (e_cs) begin m_own[ca] = 1; m_kprod[ca] = 0; m_tid[ca] = ct; end
    if (e_cd) begin m_own[ca] = 0; m_val[ca] = m_side[ca]; end
    if (mr && mw && !e_mb) m_val[ma] = md;
    ew_v = nv; ew_t = nt;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [3:0] a);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, a, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_own[i] = 0; m_kprod[i] = 0; m_val[i] = 0; m_side[i] = 0; m_tid[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 wake_valid after reset", {63'd0, wake_valid}, 64'd0);
    for (int i = 0; i < 16; i++) rd(i[3:0]);
    // R2, R3: producer first then consumer
    step(1, 3, 8'h21, 64'hDEAD_BEEF_0000_0001, 0, 0, 0, 0, 0, 0, 0);
    rd(3);
    step(1, 3, 8'h22, 64'h1111, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 3, 8'h40, 0, 0, 0, 0);
    rd(3);
    // R4, R5: consumer first then producer
    step(0, 0, 0, 0, 1, 5, 8'h55, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 5, 8'h56, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 5, 64'hBAD);
    step(1, 5, 8'h66, 64'hCAFE_F00D_1234_5678, 0, 0, 0, 0, 0, 0, 0);
    rd(5);
    // R8: plain write and read
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 9, 64'h0123_4567_89AB_CDEF);
    rd(9);
    // R9: collisions
    step(1, 7, 8'h71, 64'h77, 1, 7, 8'h72, 1, 0, 9, 0);
    step(0, 0, 0, 0, 1, 7, 8'h73, 1, 1, 9, 64'h99);
    rd(9);
    idle();
    // double-buffered stream on flag words 0 and 1
    for (int k = 0; k < 8; k++) begin
      step(1, k[0] ? 4'd1 : 4'd0, 8'h10, 64'h5000 + k, 0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, k[0] ? 4'd1 : 4'd0, 8'h20, 0, 0, 0, 0);
    end
    // random traffic on four words
    for (int k = 0; k < 600; k++) begin
      step($urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, 255), {$urandom, $urandom},
           $urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom_range(0, 255),
           $urandom_range(0, 1) == 0, $urandom_range(0, 1) == 0, $urandom_range(0, 3), {$urandom, $urandom});
    end
    idle();
    idle();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule